// File: doc/BRIEF.md
# Serial Descrambler with Keystream Lock Control

This block sits in a 100BASE-TX style receive path after NRZI decoding. It takes one scrambled line bit per clock, qualified by a valid strobe, and returns the descrambled bit one clock later. It also finds and keeps the phase of the local keystream. The keystream comes from an 11-stage shift register with the recurrence k(n) = k(n-11) XOR k(n-9). The descrambled bit is the line bit XOR the keystream bit.

While unlocked, the block assumes the line carries idle, which is all ones before scrambling. It seeds the keystream history with the inverse of 11 received bits. It then checks the bits that follow against its own prediction. Lock is declared after a selectable number of verified idle bits. In hybrid mode, a start delimiter that follows a short idle run can also complete verification.

Once locked, a watchdog counts valid bits. Each time the idle run reaches the selected count, the watchdog restarts. If the watchdog expires, lock drops and acquisition starts again. A bypass control turns the block into a one-cycle pipe and forces the lock flag high.

Top module: `dscr_sync`

## Requirements
- R1: With bypass low, lock asserts after 11 seeding bits plus N verified idle bits, counting only valid bits, and the flag is visible one clock after the last bit. N depends on `idle_sel`: 2'b00 gives 22, 2'b01 gives 32, 2'b10 gives 42, and 2'b11 gives 22.
- R2: When hybrid mode is off and a verified bit descrambles to 0 before lock, acquisition restarts. A fresh 11-bit seed plus the full N idle bits are then needed.
- R3: When hybrid mode is on, a verification run of at least 10 idle bits followed by the 10-bit delimiter 11000 10001 (in line order, first bit leftmost) completes lock at the last delimiter bit, even when N is not reached. The same input with hybrid mode off does not lock.
- R4: While locked, `dout_bit` equals the plaintext bit that was scrambled onto the line one valid clock earlier.
- R5: With `short_tmo` = 1, lock drops on the 260th consecutive locked valid bit that does not complete an idle run of N bits.
- R6: With `short_tmo` = 0, the timeout is 2^17 bits, so lock holds through 300 bits that do not complete an idle run.
- R7: A verified idle run that reaches N bits while locked restarts the timeout count.
- R8: When `bypass` is 1, `lock` is 1 and `dout_bit` equals the `rx_bit` of the previous clock.
- R9: `dout_valid` equals `rx_valid` delayed by one clock. Cycles with `rx_valid` low change neither the lock state nor the acquisition progress.
- R10: Synchronous active-high reset clears `lock`, `dout_valid` and `dout_bit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Line bit qualifier |
| rx_bit | input | 1 | Scrambled line bit |
| idle_sel | input | 2 | Idle count select for lock |
| hybrid_en | input | 1 | Accept the idle plus delimiter sequence as proof of sync |
| short_tmo | input | 1 | 1 selects the 260-bit timeout, 0 selects the 2^17-bit timeout |
| bypass | input | 1 | Pass line bits through without descrambling |
| dout_valid | output | 1 | Output bit qualifier |
| dout_bit | output | 1 | Descrambled bit |
| lock | output | 1 | Keystream lock flag |

## Verification
The hardest state to reach from the ports is a locked keystream that must then be starved of idle, or fed a delimiter at an exact bit phase. Both need line bits that are correctly scrambled. The bench therefore runs its own scrambler model and sends chosen plaintext through it: idle to seed and verify, delimiter patterns at counted positions, and runs of plaintext zeros to drive the watchdog to its limit or to break verification on purpose.

// File: rtl/dscr_sync_pkg.sv
package dscr_sync_pkg;

   typedef enum logic [1:0] {
      ST_SEED   = 2'd0,
      ST_CHECK  = 2'd1,
      ST_DELIM  = 2'd2,
      ST_LOCKED = 2'd3
   } sync_state_t;

   // delimiter in line order, first bit is the MSB
   localparam int          DELIM_LEN   = 10;
   localparam logic [9:0]  DELIM_PAT   = 10'b1100010001;
   // position of the first zero of the delimiter
   localparam int          DELIM_FIRST0 = 2;

endpackage

// File: rtl/dscr_sync_keygen.sv
module dscr_sync_keygen #(
   parameter int STAGES = 11,
   parameter int TAP    = 9
) (
   input  logic clk,
   input  logic rst,
   input  logic adv,
   input  logic seed_mode,
   input  logic rx_bit,
   output logic key_bit
);

   generate
      if (TAP < 1 || TAP >= STAGES) begin : g_bad_tap
         $error("keygen: TAP must lie in 1..STAGES-1");
      end
   endgenerate

   // hist[i] holds the keystream bit of i+1 bit times ago
   logic [STAGES-1:0] hist;

   assign key_bit = hist[STAGES-1] ^ hist[TAP-1];

   always_ff @(posedge clk) begin
      if (rst) begin
         hist <= '0;
      end else if (adv) begin
         hist <= {hist[STAGES-2:0], seed_mode ? ~rx_bit : key_bit};
      end
   end

endmodule

// File: rtl/dscr_sync_fsm.sv
module dscr_sync_fsm
   import dscr_sync_pkg::*;
#(
   parameter int STAGES       = 11,
   parameter int RUN_W        = 6,
   parameter int HYB_MIN_IDLE = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             adv,
   input  logic             dbit,
   input  logic             hybrid_en,
   input  logic [RUN_W-1:0] need,
   input  logic             tmo_hit,
   output logic             seed_mode,
   output logic             locked,
   output logic             run_hit
);

   localparam int FILL_W = $clog2(STAGES);
   localparam int IDX_W  = $clog2(DELIM_LEN);
   localparam logic [RUN_W-1:0] HYB_GATE  = RUN_W'(HYB_MIN_IDLE + DELIM_FIRST0);
   localparam logic [FILL_W-1:0] FILL_END = FILL_W'(STAGES - 1);
   localparam logic [IDX_W-1:0]  IDX_END  = IDX_W'(DELIM_LEN - 1);
   localparam logic [IDX_W-1:0]  IDX_NEXT = IDX_W'(DELIM_FIRST0 + 1);

   sync_state_t       st;
   logic [FILL_W-1:0] fill;
   logic [RUN_W-1:0]  run;
   logic [IDX_W-1:0]  idx;
   logic [RUN_W-1:0]  run_inc;
   logic              run_full;
   logic              delim_exp;

   assign run_inc   = run + 1'b1;
   assign run_full  = (run_inc >= need);
   assign delim_exp = DELIM_PAT[IDX_END - idx];
   assign seed_mode = (st == ST_SEED);
   assign locked    = (st == ST_LOCKED);
   assign run_hit   = adv && locked && dbit && run_full;

   always_ff @(posedge clk) begin
      if (rst) begin
         st   <= ST_SEED;
         fill <= '0;
         run  <= '0;
         idx  <= '0;
      end else if (adv) begin
         unique case (st)
            ST_SEED: begin
               if (fill == FILL_END) begin
                  fill <= '0;
                  run  <= '0;
                  st   <= ST_CHECK;
               end else begin
                  fill <= fill + 1'b1;
               end
            end
            ST_CHECK: begin
               if (dbit) begin
                  if (run_full) begin
                     run <= '0;
                     st  <= ST_LOCKED;
                  end else begin
                     run <= run_inc;
                  end
               end else if (hybrid_en && run >= HYB_GATE) begin
                  idx <= IDX_NEXT;
                  st  <= ST_DELIM;
               end else begin
                  fill <= '0;
                  st   <= ST_SEED;
               end
            end
            ST_DELIM: begin
               if (dbit != delim_exp) begin
                  fill <= '0;
                  st   <= ST_SEED;
               end else if (idx == IDX_END) begin
                  run <= '0;
                  st  <= ST_LOCKED;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            ST_LOCKED: begin
               if (tmo_hit) begin
                  fill <= '0;
                  st   <= ST_SEED;
               end else if (dbit) begin
                  run <= run_full ? run : run_inc;
               end else begin
                  run <= '0;
               end
            end
            default: st <= ST_SEED;
         endcase
      end
   end

endmodule

// File: rtl/dscr_sync_watchdog.sv
module dscr_sync_watchdog #(
   parameter int LONG_LIM  = 131072,
   parameter int SHORT_LIM = 260
) (
   input  logic clk,
   input  logic rst,
   input  logic en,
   input  logic clr,
   input  logic short_sel,
   output logic expire
);

   localparam int CNT_W = $clog2(LONG_LIM);
   localparam logic [CNT_W-1:0] LAST_L = CNT_W'(LONG_LIM - 1);
   localparam logic [CNT_W-1:0] LAST_S = CNT_W'(SHORT_LIM - 1);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] last;

   generate
      if (SHORT_LIM < 2 || SHORT_LIM > LONG_LIM) begin : g_bad_lim
         $error("watchdog: need 2 <= SHORT_LIM <= LONG_LIM");
      end
      if (SHORT_LIM == LONG_LIM) begin : g_one_lim
         assign last = LAST_L;
      end else begin : g_two_lim
         assign last = short_sel ? LAST_S : LAST_L;
      end
   endgenerate

   assign expire = en && !clr && (cnt == last);

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         cnt <= '0;
      end else if (en) begin
         cnt <= expire ? '0 : cnt + 1'b1;
      end
   end

endmodule

// File: rtl/dscr_sync.sv
module dscr_sync #(
   parameter int STAGES       = 11,
   parameter int TAP          = 9,
   parameter int IDLE_BASE    = 22,
   parameter int IDLE_STEP    = 10,
   parameter int HYB_MIN_IDLE = 10,
   parameter int LONG_LIM     = 131072,
   parameter int SHORT_LIM    = 260
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       rx_valid,
   input  logic       rx_bit,
   input  logic [1:0] idle_sel,
   input  logic       hybrid_en,
   input  logic       short_tmo,
   input  logic       bypass,
   output logic       dout_valid,
   output logic       dout_bit,
   output logic       lock
);

   localparam int RUN_W = $clog2(IDLE_BASE + 2 * IDLE_STEP + 2);
   localparam logic [RUN_W-1:0] NEED0 = RUN_W'(IDLE_BASE);
   localparam logic [RUN_W-1:0] NEED1 = RUN_W'(IDLE_BASE + IDLE_STEP);
   localparam logic [RUN_W-1:0] NEED2 = RUN_W'(IDLE_BASE + 2 * IDLE_STEP);

   generate
      if (IDLE_BASE < 1 || HYB_MIN_IDLE < 1) begin : g_bad_cnt
         $error("dscr_sync: idle counts must be positive");
      end
   endgenerate

   logic             key_bit;
   logic             dbit;
   logic             seed_mode;
   logic             locked_q;
   logic             run_hit;
   logic             tmo_hit;
   logic [RUN_W-1:0] need;

   always_comb begin
      unique case (idle_sel)
         2'b01:   need = NEED1;
         2'b10:   need = NEED2;
         default: need = NEED0;
      endcase
   end

   assign dbit = rx_bit ^ key_bit;

   dscr_sync_keygen #(
      .STAGES (STAGES),
      .TAP    (TAP)
   ) u_keygen (
      .clk       (clk),
      .rst       (rst),
      .adv       (rx_valid),
      .seed_mode (seed_mode),
      .rx_bit    (rx_bit),
      .key_bit   (key_bit)
   );

   dscr_sync_fsm #(
      .STAGES       (STAGES),
      .RUN_W        (RUN_W),
      .HYB_MIN_IDLE (HYB_MIN_IDLE)
   ) u_fsm (
      .clk       (clk),
      .rst       (rst),
      .adv       (rx_valid),
      .dbit      (dbit),
      .hybrid_en (hybrid_en),
      .need      (need),
      .tmo_hit   (tmo_hit),
      .seed_mode (seed_mode),
      .locked    (locked_q),
      .run_hit   (run_hit)
   );

   dscr_sync_watchdog #(
      .LONG_LIM  (LONG_LIM),
      .SHORT_LIM (SHORT_LIM)
   ) u_wdog (
      .clk       (clk),
      .rst       (rst),
      .en        (locked_q && rx_valid),
      .clr       (!locked_q || run_hit),
      .short_sel (short_tmo),
      .expire    (tmo_hit)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         dout_valid <= 1'b0;
         dout_bit   <= 1'b0;
      end else begin
         dout_valid <= rx_valid;
         dout_bit   <= bypass ? rx_bit : dbit;
      end
   end

   assign lock = bypass || locked_q;

endmodule

// File: rtl/dscr_sync_chk.sv
module dscr_sync_chk (
   input logic clk,
   input logic rst,
   input logic rx_valid,
   input logic rx_bit,
   input logic bypass,
   input logic dout_valid,
   input logic dout_bit,
   input logic locked_q,
   input logic tmo_hit
);

   // R9
   valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (dout_valid == $past(rx_valid)));

   // R8
   bypass_pass_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(bypass)) |-> (dout_bit == $past(rx_bit)));

   // R5
   lock_fall_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(locked_q) |-> $past(tmo_hit));

   // R1
   lock_rise_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(locked_q) |-> $past(rx_valid));

   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !rx_valid |=> $stable(locked_q));

endmodule

bind dscr_sync dscr_sync_chk u_chk (
   .clk        (clk),
   .rst        (rst),
   .rx_valid   (rx_valid),
   .rx_bit     (rx_bit),
   .bypass     (bypass),
   .dout_valid (dout_valid),
   .dout_bit   (dout_bit),
   .locked_q   (locked_q),
   .tmo_hit    (tmo_hit)
);

// File: tb/dscr_sync_test.sv
module dscr_sync_test;

   logic       clk = 1'b0;
   logic       rst;
   logic       rx_valid;
   logic       rx_bit;
   logic [1:0] idle_sel;
   logic       hybrid_en;
   logic       short_tmo;
   logic       bypass;
   logic       dout_valid;
   logic       dout_bit;
   logic       lock;

   int n_chk  = 0;
   int n_fail = 0;

   // transmit scrambler model: k(n) = k(n-11) ^ k(n-9)
   logic [10:0] tx_st = 11'h5A3;

   always #5 clk = ~clk;

   dscr_sync uut (
      .clk        (clk),
      .rst        (rst),
      .rx_valid   (rx_valid),
      .rx_bit     (rx_bit),
      .idle_sel   (idle_sel),
      .hybrid_en  (hybrid_en),
      .short_tmo  (short_tmo),
      .bypass     (bypass),
      .dout_valid (dout_valid),
      .dout_bit   (dout_bit),
      .lock       (lock)
   );

   // {idle_sel, expected idle count}
   localparam int NV = 4;
   localparam logic [7:0] LOCK_VEC [NV] = '{
      {2'b00, 6'd22},
      {2'b01, 6'd32},
      {2'b10, 6'd42},
      {2'b11, 6'd22}
   };

   task automatic chk(input string req, input logic got, input logic exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b", req, got, exp);
      end
   endtask

   task automatic send_raw(input logic v, input logic b);
      @(negedge clk);
      rx_valid = v;
      rx_bit   = b;
      @(posedge clk);
      #1;
   endtask

   task automatic send_data(input logic d);
      logic k;
      k     = tx_st[10] ^ tx_st[8];
      tx_st = {tx_st[9:0], k};
      send_raw(1'b1, d ^ k);
   endtask

   task automatic send_n(input int n, input logic d);
      for (int i = 0; i < n; i++) send_data(d);
   endtask

   task automatic send_delim();
      for (int i = 9; i >= 0; i--) send_data(dscr_sync_pkg::DELIM_PAT[i]);
   endtask

   task automatic do_reset(input logic [1:0] sel, input logic hyb,
                           input logic sh, input logic bp);
      @(negedge clk);
      rst       = 1'b1;
      rx_valid  = 1'b0;
      rx_bit    = 1'b0;
      idle_sel  = sel;
      hybrid_en = hyb;
      short_tmo = sh;
      bypass    = bp;
      repeat (3) @(posedge clk);
      #1;
      @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      rst = 1'b1;
      rx_valid = 1'b0;
      rx_bit = 1'b0;
      idle_sel = 2'b00;
      hybrid_en = 1'b0;
      short_tmo = 1'b0;
      bypass = 1'b0;

      // R10 reset state
      do_reset(2'b00, 1'b0, 1'b0, 1'b0);
      chk("R10 lock", lock, 1'b0);
      chk("R10 dout_valid", dout_valid, 1'b0);
      chk("R10 dout_bit", dout_bit, 1'b0);

      // R1 lock count per idle select, walked from the table
      for (int v = 0; v < NV; v++) begin
         do_reset(LOCK_VEC[v][7:6], 1'b0, 1'b0, 1'b0);
         send_n(11 + int'(LOCK_VEC[v][5:0]) - 1, 1'b1);
         chk("R1 before count", lock, 1'b0);
         send_data(1'b1);
         chk("R1 at count", lock, 1'b1);
      end

      // R4 descrambled data while locked (lock held from last vector)
      for (int i = 0; i < 24; i++) begin
         logic d;
         d = logic'((i * 7 + i / 3) % 2);
         send_data(d);
         chk("R4 data", dout_bit, d);
      end

      // R2 verification error restarts acquisition
      do_reset(2'b00, 1'b0, 1'b0, 1'b0);
      send_n(11 + 15, 1'b1);
      send_data(1'b0);
      send_n(11 + 21, 1'b1);
      chk("R2 not yet", lock, 1'b0);
      send_data(1'b1);
      chk("R2 relocked", lock, 1'b1);

      // R3 hybrid delimiter completes lock early
      do_reset(2'b10, 1'b1, 1'b0, 1'b0);
      send_n(11 + 10, 1'b1);
      send_delim();
      chk("R3 hybrid lock", lock, 1'b1);

      // R3 same sequence without hybrid mode
      do_reset(2'b10, 1'b0, 1'b0, 1'b0);
      send_n(11 + 10, 1'b1);
      send_delim();
      chk("R3 no hybrid", lock, 1'b0);

      // R5 short timeout
      do_reset(2'b00, 1'b0, 1'b1, 1'b0);
      send_n(11 + 22, 1'b1);
      chk("R5 locked", lock, 1'b1);
      send_n(259, 1'b0);
      chk("R5 before limit", lock, 1'b1);
      send_data(1'b0);
      chk("R5 at limit", lock, 1'b0);

      // R7 idle run restarts the timeout
      do_reset(2'b00, 1'b0, 1'b1, 1'b0);
      send_n(11 + 22, 1'b1);
      send_n(200, 1'b0);
      send_n(22, 1'b1);
      send_n(200, 1'b0);
      chk("R7 restarted", lock, 1'b1);
      send_n(59, 1'b0);
      chk("R7 before limit", lock, 1'b1);
      send_data(1'b0);
      chk("R7 at limit", lock, 1'b0);

      // R6 long timeout holds lock
      do_reset(2'b00, 1'b0, 1'b0, 1'b0);
      send_n(11 + 22, 1'b1);
      send_n(300, 1'b0);
      chk("R6 long window", lock, 1'b1);

      // R9 invalid cycles are ignored, valid delayed by one
      do_reset(2'b00, 1'b0, 1'b0, 1'b0);
      for (int i = 0; i < 32; i++) begin
         send_data(1'b1);
         if (i % 3 == 0) begin
            send_raw(1'b0, logic'(i % 2));
            if (i == 3) chk("R9 valid low", dout_valid, 1'b0);
         end
      end
      chk("R9 valid high", dout_valid, 1'b1);
      chk("R9 gaps before count", lock, 1'b0);
      send_data(1'b1);
      chk("R9 gaps at count", lock, 1'b1);

      // R8 bypass
      do_reset(2'b00, 1'b0, 1'b0, 1'b1);
      chk("R8 lock", lock, 1'b1);
      for (int i = 0; i < 6; i++) begin
         logic b;
         b = logic'((i ^ (i >> 1)) & 1);
         send_raw(1'b1, b);
         chk("R8 pass", dout_bit, b);
      end

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule